// File: doc/BRIEF.md
# Dual-channel UART host bus front-end

This block connects an asynchronous 8-bit host bus to two identical UART register files, called channel A and channel B. The host drives an active-low chip select, a channel select, three address lines and active-low read and write strobes. The block decodes these signals so that exactly one channel's register file is read or written. Read data comes back on a shared data bus through a driver enable that is active only during a selected read. Reads are purely combinational, so a read needs no internal clock to complete. Writes are committed on the rising edge of the write strobe, which the block detects on an internal clock.

Each channel also owns a multifunction output pin. A 2-bit field in that channel's alternate function register picks what the pin shows:

- the general-purpose output,
- the baud clock output,
- the receive-ready indication, or
- a constant inactive level.

The serializers, FIFOs and baud logic sit outside the block. They deliver those three active-low status signals per channel.

Two resets are provided. rst_ni is an asynchronous power-on reset. reset_i is a functional reset that is active high and sampled on the clock. Both resets return every register of both channels to zero.

Top module: `dual_uart_hostbus`

## Requirements
- R1: With cs_n_i low and chsel_i = 1, a completed write lands in channel A (index 1 of the per-channel ports) at address addr_i, and channel B's register at that address is unchanged.
- R2: With cs_n_i low and chsel_i = 0, a completed write lands in channel B (index 0), and channel A is unchanged.
- R3: A write strobe issued while cs_n_i is high changes no register in either channel, whatever chsel_i is.
- R4: While cs_n_i and rd_n_i are both low, data_o shows the register of the channel picked by chsel_i at address addr_i, with no clock edge needed.
- R5: data_oe_o is high only while cs_n_i and rd_n_i are both low, and is low otherwise.
- R6: A write takes effect only after wr_n_i rises. The register updates within three clock cycles of the rise. While the strobe stays low, the addressed register, and the pin it controls, keep their old value.
- R7: The field at bits [2:1] of register address 5 picks the channel's mf_n_o: 00 gives op2_n_i, 01 gives baud_n_i, 10 gives rxrdy_n_i, and 11 drives it constant 1. The other bits of that register have no effect on the pin.
- R8: The two channels' select fields are independent, so mf_n_o[1] and mf_n_o[0] can show different sources at the same time.
- R9: reset_i held high across one rising clock edge clears all registers of both channels to 0, so both pins show op2_n_i.
- R10: rst_ni low clears all registers of both channels at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock used for strobe edge detection and reset sampling |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| reset_i | input | 1 | Functional reset, active high, sampled on clk_i |
| cs_n_i | input | 1 | Chip select, active low |
| chsel_i | input | 1 | Channel select: 1 = channel A, 0 = channel B |
| addr_i | input | 3 | Register address within the channel |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low, committed on its rising edge |
| data_i | input | 8 | Write data from the host bus |
| data_o | output | 8 | Read data to the host bus |
| data_oe_o | output | 1 | Host bus driver enable; bus released when low |
| op2_n_i | input | 2 | Per-channel general-purpose output level ([1] = A, [0] = B) |
| baud_n_i | input | 2 | Per-channel baud clock output ([1] = A, [0] = B) |
| rxrdy_n_i | input | 2 | Per-channel receive-ready indication ([1] = A, [0] = B) |
| mf_n_o | output | 2 | Per-channel multifunction pin ([1] = A, [0] = B) |

## Verification
The bench writes registers in both channels at the same addresses. After each write it reads the other channel back. A decoder that swapped the meaning of chsel_i, or that let a write reach both channels, would corrupt the neighbour and be caught there. Writes with chip select high are followed by readback of both channels, which exposes a qualifier that was dropped from the commit path. The select field is swept through all four codes against one-hot status patterns, which separates a mux with crossed inputs, and a code 11 that passed a status signal through, from the correct one. The bench also holds the write strobe low and watches the multifunction pin, so a design that committed on the falling edge would move the pin early. Finally it pulses each reset with registers loaded, catching a reset that missed one channel or the pin path.

// File: rtl/dual_uart_hostbus_pkg.sv
package dual_uart_hostbus_pkg;
  parameter int unsigned DW       = 8;
  parameter int unsigned AW       = 3;
  parameter int unsigned NCH      = 2;
  parameter int unsigned AFR_ADDR = 5;
  parameter int unsigned MF_LSB   = 1;
  localparam int unsigned NREG    = 1 << AW;

  typedef struct packed {
    logic          cs_n;
    logic          chsel;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } bus_cap_t;

  typedef enum logic [1:0] {
    MF_OP2   = 2'b00,
    MF_BAUD  = 2'b01,
    MF_RXRDY = 2'b10,
    MF_IDLE  = 2'b11
  } mf_sel_e;
endpackage

// File: rtl/hub_wr_capture.sv
module hub_wr_capture
  import dual_uart_hostbus_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          cs_n_i,
  input  logic          chsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          wr_n_i,
  output logic [NCH-1:0] we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  localparam bus_cap_t CAP_IDLE = '{cs_n: 1'b1, chsel: 1'b0, addr: '0, data: '0};

  logic     wr_s1, wr_s2;
  bus_cap_t cap_q;
  logic     commit;

  // two-stage sync on the strobe; bus fields sampled while it is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_s1 <= 1'b1;
      wr_s2 <= 1'b1;
      cap_q <= CAP_IDLE;
    end else if (srst_i) begin
      wr_s1 <= 1'b1;
      wr_s2 <= 1'b1;
      cap_q <= CAP_IDLE;
    end else begin
      wr_s1 <= wr_n_i;
      wr_s2 <= wr_s1;
      if (!wr_n_i) cap_q <= '{cs_n: cs_n_i, chsel: chsel_i, addr: addr_i, data: data_i};
    end
  end

  assign commit  = wr_s1 & ~wr_s2 & ~cap_q.cs_n & ~srst_i;
  assign waddr_o = cap_q.addr;
  assign wdata_o = cap_q.data;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_we
    assign we_o[ch] = commit & (cap_q.chsel == 1'(ch));
  end

  // one strobe rise yields one commit, never two back to back
  p_single_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |=> !(|we_o));
endmodule

// File: rtl/hub_chan_regs.sv
module hub_chan_regs
  import dual_uart_hostbus_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          op2_n_i,
  input  logic          baud_n_i,
  input  logic          rxrdy_n_i,
  output logic          mf_n_o
);
  localparam logic [AW-1:0] AFR_IDX = AW'(AFR_ADDR);

  logic [NREG-1:0][DW-1:0] regs;
  mf_sel_e                 mf_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      regs <= '0;
    else if (srst_i)  regs <= '0;
    else if (we_i)    regs[waddr_i] <= wdata_i;
  end

  assign rdata_o = regs[raddr_i];
  assign mf_sel  = mf_sel_e'(regs[AFR_IDX][MF_LSB +: 2]);

  always_comb begin
    unique case (mf_sel)
      MF_OP2:   mf_n_o = op2_n_i;
      MF_BAUD:  mf_n_o = baud_n_i;
      MF_RXRDY: mf_n_o = rxrdy_n_i;
      default:  mf_n_o = 1'b1;
    endcase
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !srst_i) |=> $stable(regs));
  p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !srst_i) |=> (regs[$past(waddr_i)] == $past(wdata_i)));
  p_sreset_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (regs == '0));
endmodule

// File: rtl/dual_uart_hostbus.sv
module dual_uart_hostbus
  import dual_uart_hostbus_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reset_i,
  input  logic           cs_n_i,
  input  logic           chsel_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           rd_n_i,
  input  logic           wr_n_i,
  input  logic [DW-1:0]  data_i,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o,
  input  logic [NCH-1:0] op2_n_i,
  input  logic [NCH-1:0] baud_n_i,
  input  logic [NCH-1:0] rxrdy_n_i,
  output logic [NCH-1:0] mf_n_o
);
  logic [NCH-1:0] we;
  logic [AW-1:0]  waddr;
  logic [DW-1:0]  wdata;
  logic [DW-1:0]  rdata [NCH];

  hub_wr_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (reset_i),
    .cs_n_i  (cs_n_i),
    .chsel_i (chsel_i),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .wr_n_i  (wr_n_i),
    .we_o    (we),
    .waddr_o (waddr),
    .wdata_o (wdata)
  );

  // index 1 = channel A, index 0 = channel B (matches chsel_i value)
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    hub_chan_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .srst_i    (reset_i),
      .we_i      (we[ch]),
      .waddr_i   (waddr),
      .wdata_i   (wdata),
      .raddr_i   (addr_i),
      .rdata_o   (rdata[ch]),
      .op2_n_i   (op2_n_i[ch]),
      .baud_n_i  (baud_n_i[ch]),
      .rxrdy_n_i (rxrdy_n_i[ch]),
      .mf_n_o    (mf_n_o[ch])
    );
  end

  // read path is clockless: strobe and select only
  assign data_oe_o = ~cs_n_i & ~rd_n_i;
  assign data_o    = data_oe_o ? rdata[chsel_i] : '0;
endmodule

// File: tb/dual_uart_hostbus_bench.sv
module dual_uart_hostbus_bench;
  typedef struct packed {
    logic       ch;
    logic [2:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 8'h11}, '{1'b0, 3'd0, 8'h22},
    '{1'b1, 3'd7, 8'h7e}, '{1'b0, 3'd7, 8'h81},
    '{1'b1, 3'd3, 8'hc3}, '{1'b0, 3'd3, 8'h3c},
    '{1'b1, 3'd6, 8'ha5}, '{1'b0, 3'd1, 8'h5a}
  };

  logic       clk = 1'b0;
  logic       rst_ni, reset_i, cs_n, chsel, rd_n, wr_n;
  logic [2:0] addr;
  logic [7:0] din, dout;
  logic       doe;
  logic [1:0] op2_n, baud_n, rxrdy_n, mf_n;
  int         tests = 0, fails = 0;
  logic [7:0] rv;
  logic       ro;

  always #10 clk = ~clk;

  dual_uart_hostbus u_dual_uart_hostbus (
    .clk_i(clk), .rst_ni(rst_ni), .reset_i(reset_i), .cs_n_i(cs_n), .chsel_i(chsel),
    .addr_i(addr), .rd_n_i(rd_n), .wr_n_i(wr_n), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .op2_n_i(op2_n), .baud_n_i(baud_n), .rxrdy_n_i(rxrdy_n),
    .mf_n_o(mf_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_start(input logic ch, input logic [2:0] a, input logic [7:0] d, input logic csn);
    @(negedge clk);
    cs_n = csn; chsel = ch; addr = a; din = d; wr_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_end();
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; din = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic ch, input logic [2:0] a, input logic [7:0] d);
    wr_start(ch, a, d, 1'b0);
    wr_end();
  endtask

  task automatic do_read(input logic ch, input logic [2:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; chsel = ch; addr = a; rd_n = 1'b0;
    #5;
    v = dout; oe = doe;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  // only status source k is high on both channels
  task automatic set_pat(input int k);
    op2_n   = (k == 0) ? 2'b11 : 2'b00;
    baud_n  = (k == 1) ? 2'b11 : 2'b00;
    rxrdy_n = (k == 2) ? 2'b11 : 2'b00;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; reset_i = 1'b0; cs_n = 1'b1; chsel = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; din = '0; op2_n = 2'b00; baud_n = 2'b00; rxrdy_n = 2'b00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    for (int a = 0; a < 8; a++) begin
      do_read(1'b1, 3'(a), rv, ro); chk("R10 reset A", rv, 8'h00);
      do_read(1'b0, 3'(a), rv, ro); chk("R10 reset B", rv, 8'h00);
    end
    op2_n = 2'b10; #1; chk("R9 reset pin op2", {6'd0, mf_n}, 8'h02);
    op2_n = 2'b01; #1; chk("R9 reset pin op2", {6'd0, mf_n}, 8'h01);

    // R5 driver enable
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #5; chk("R5 cs high", {7'd0, doe}, 8'h00);
    cs_n = 1'b0; rd_n = 1'b1; #2; chk("R5 rd high", {7'd0, doe}, 8'h00);
    rd_n = 1'b0; #2; chk("R5 both low", {7'd0, doe}, 8'h01);
    cs_n = 1'b1; rd_n = 1'b1; #2; chk("R5 idle", {7'd0, doe}, 8'h00);

    // vector table: write, read back, and check the other channel
    for (int i = 0; i < NV; i++) begin
      logic [7:0] oexp;
      oexp = 8'h00;
      for (int j = 0; j < i; j++)
        if (VEC[j].ch != VEC[i].ch && VEC[j].addr == VEC[i].addr) oexp = VEC[j].data;
      do_write(VEC[i].ch, VEC[i].addr, VEC[i].data);
      do_read(VEC[i].ch, VEC[i].addr, rv, ro);
      chk(VEC[i].ch ? "R1 write A" : "R2 write B", rv, VEC[i].data);
      chk("R4 read oe", {7'd0, ro}, 8'h01);
      do_read(~VEC[i].ch, VEC[i].addr, rv, ro);
      chk(VEC[i].ch ? "R1 B untouched" : "R2 A untouched", rv, oexp);
    end
    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i].ch, VEC[i].addr, rv, ro);
      chk("R4 final readback", rv, VEC[i].data);
    end

    // R3 deselected writes
    wr_start(1'b1, 3'd2, 8'hff, 1'b1); wr_end();
    wr_start(1'b0, 3'd2, 8'hee, 1'b1); wr_end();
    do_read(1'b1, 3'd2, rv, ro); chk("R3 A ignored", rv, 8'h00);
    do_read(1'b0, 3'd2, rv, ro); chk("R3 B ignored", rv, 8'h00);
    do_read(1'b1, 3'd0, rv, ro); chk("R3 A0 kept", rv, 8'h11);

    // R7 all codes on channel A, one-hot status patterns
    do_write(1'b0, 3'd5, 8'h00);
    for (int sel = 0; sel < 4; sel++) begin
      do_write(1'b1, 3'd5, 8'(sel << 1));
      for (int k = 0; k < 3; k++) begin
        set_pat(k);
        chk("R7 mux A", {7'd0, mf_n[1]}, (sel == 3 || sel == k) ? 8'h01 : 8'h00);
      end
    end
    do_write(1'b1, 3'd5, 8'hf9);
    for (int k = 0; k < 3; k++) begin
      set_pat(k);
      chk("R7 other bits ignored", {7'd0, mf_n[1]}, (k == 0) ? 8'h01 : 8'h00);
    end

    // R8 independent selections
    do_write(1'b1, 3'd5, 8'h04);
    do_write(1'b0, 3'd5, 8'h02);
    set_pat(1); chk("R8 A rxrdy B baud", {6'd0, mf_n}, 8'h01);
    set_pat(2); chk("R8 A rxrdy B baud", {6'd0, mf_n}, 8'h02);
    set_pat(0); chk("R8 A rxrdy B baud", {6'd0, mf_n}, 8'h00);

    // R6 commit only after strobe rise (A from rxrdy to idle)
    set_pat(1);
    wr_start(1'b1, 3'd5, 8'h06, 1'b0);
    @(negedge clk); #1;
    chk("R6 held strobe", {7'd0, mf_n[1]}, 8'h00);
    wr_end();
    chk("R6 after rise", {7'd0, mf_n[1]}, 8'h01);

    // R9 one-cycle functional reset
    @(negedge clk); reset_i = 1'b1;
    @(negedge clk); reset_i = 1'b0;
    do_read(1'b1, 3'd0, rv, ro); chk("R9 A cleared", rv, 8'h00);
    do_read(1'b0, 3'd7, rv, ro); chk("R9 B cleared", rv, 8'h00);
    do_read(1'b1, 3'd5, rv, ro); chk("R9 A sel cleared", rv, 8'h00);
    set_pat(0); chk("R9 pins op2", {6'd0, mf_n}, 8'h03);

    // R10 async reset between edges
    do_write(1'b1, 3'd4, 8'h99);
    do_write(1'b0, 3'd4, 8'h66);
    @(negedge clk); #3; rst_ni = 1'b0; #2;
    cs_n = 1'b0; rd_n = 1'b0; chsel = 1'b1; addr = 3'd4; #1;
    chk("R10 A async clear", dout, 8'h00);
    chsel = 1'b0; #1;
    chk("R10 B async clear", dout, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule